// File: doc/BRIEF.md
# Privilege Mode and Virtual Segment Decoder

This block turns three processor status fields into a privilege level and sorts a 32-bit virtual address into one of four fixed regions of the address space. The three fields are a two-bit mode selector, an error-level flag and an exception-level flag. For the two kernel regions that bypass translation, it also forms the physical address. It reports whether an access is cacheable and whether the address needs translation by a TLB. The lookup itself happens elsewhere. It raises an address-error flag when the current level is not allowed to touch the region. That flag is split into store-type and load/fetch-type faults, using an access-kind tag.

The decode is combinational. A single output register captures it one cycle after a valid input and holds it while the valid input is low. The register is controlled by a two-state machine:
- `ST_EMPTY` means nothing has been captured since reset.
- `ST_LOADED` means the outputs carry a decode.

There are two transitions. `ST_EMPTY -> ST_LOADED` is taken on the first `in_valid`. `ST_LOADED -> ST_LOADED` is taken on every later cycle, and a new decode is captured only when `in_valid` is high. Reset returns the machine to `ST_EMPTY`.

Top module: `privseg_decoder`

## Requirements
- R1: The decoded level is kernel (`out_mode` = 0) whenever `in_err_lvl` is 1 or `in_exc_lvl` is 1, whatever the mode selector holds. It is also kernel when both flags are 0 and the selector is 00.
- R2: With both flags 0, a selector of 01 gives supervisor (`out_mode` = 1). A selector of 10 or 11 gives user (`out_mode` = 2).
- R3: `out_seg` classifies the address by its top bits:
  - 0 (user) for 0x00000000–0x7FFFFFFF
  - 1 (cached direct) for 0x80000000–0x9FFFFFFF
  - 2 (uncached direct) for 0xA0000000–0xBFFFFFFF
  - 3 (mapped kernel) for 0xC0000000–0xFFFFFFFF
- R4: `out_mapped` is 1 for segments 0 and 3 and 0 for segments 1 and 2. For mapped segments `out_paddr` is 0.
- R5: For segments 1 and 2, `out_paddr` is the virtual address with its top three bits cleared, so both reach the low 512 MB. The reset fetch address 0xBFC00000 lands in segment 2 with physical address 0x1FC00000.
- R6: `out_cacheable` is 0 for segment 2 and 1 for every other segment.
- R7: At user level, only segment 0 is reachable. Any other address sets `out_addr_err`.
- R8: At supervisor level, segment 0 and the window 0xC0000000–0xDFFFFFFF are reachable. Any other address sets `out_addr_err`.
- R9: At kernel level, `out_addr_err` is never set.
- R10: The access kind on `in_kind` is 00 load, 01 store, 10 fetch. `out_err_is_store` is 1 only when `out_addr_err` is 1 and the kind is store. A fetch or load fault leaves it 0.
- R11: A decode appears on the outputs one clock after `in_valid` is high, and `out_valid` then rises. While `in_valid` is low, every output keeps its value.
- R12: After reset, `out_valid` is 0 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture the decode of the present inputs |
| in_mode_field | input | 2 | Mode selector from the status word |
| in_err_lvl | input | 1 | Error-level flag |
| in_exc_lvl | input | 1 | Exception-level flag |
| in_vaddr | input | 32 | Virtual address |
| in_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| out_valid | output | 1 | Outputs hold a captured decode |
| out_mode | output | 2 | Level: 0 kernel, 1 supervisor, 2 user |
| out_seg | output | 2 | Segment code |
| out_mapped | output | 1 | Address needs TLB translation |
| out_paddr | output | 32 | Physical address for direct segments, else 0 |
| out_cacheable | output | 1 | Access may be cached |
| out_addr_err | output | 1 | Level may not reach the segment |
| out_err_is_store | output | 1 | The fault is store-type |

## Verification
The assertions take for granted two things about the inputs: they carry known values whenever `in_valid` is high, and they stay steady across the sampling edge. The bench meets both conditions by changing every input only on the falling clock edge and by never leaving a field undriven. The properties tie the inputs sampled with `in_valid` to the outputs one cycle later. They therefore also assume that no decode is requested during reset, so the stimulus holds `in_valid` low until reset is released.

// File: rtl/privseg_pkg.sv
package privseg_pkg;

    localparam int VADDR_W   = 32;
    localparam int SEL_W     = 3;
    localparam int DIRECT_W  = VADDR_W - SEL_W;
    localparam int MODEF_W   = 2;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_SUPER  = 2'd1,
        MODE_USER   = 2'd2
    } priv_mode_e;

    typedef enum logic [1:0] {
        SEG_USER      = 2'd0,
        SEG_KDIRECT_C = 2'd1,
        SEG_KDIRECT_U = 2'd2,
        SEG_KMAPPED   = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } hold_state_e;

    typedef struct packed {
        priv_mode_e           mode;
        seg_e                 seg;
        logic                 mapped;
        logic [VADDR_W-1:0]   paddr;
        logic                 cacheable;
        logic                 addr_err;
        logic                 err_store;
    } decode_t;

endpackage

// File: rtl/priv_level_decode.sv
module priv_level_decode
    import privseg_pkg::*;
(
    input  logic [MODEF_W-1:0] mode_field,
    input  logic               err_lvl,
    input  logic               exc_lvl,
    output priv_mode_e         level
);

    always_comb begin
        if (err_lvl || exc_lvl) begin
            level = MODE_KERNEL;
        end else begin
            unique case (mode_field)
                2'b00:   level = MODE_KERNEL;
                2'b01:   level = MODE_SUPER;
                2'b10:   level = MODE_USER;
                default: level = MODE_USER;
            endcase
        end
    end

endmodule

// File: rtl/vaddr_segment_map.sv
module vaddr_segment_map
    import privseg_pkg::*;
(
    input  logic [VADDR_W-1:0] vaddr,
    output seg_e               seg,
    output logic               mapped,
    output logic [VADDR_W-1:0] paddr,
    output logic               cacheable,
    output logic               super_window
);

    localparam logic [SEL_W-1:0] SUPER_SEL = 3'b110;

    logic [SEL_W-1:0] sel;
    logic             direct;

    assign sel = vaddr[VADDR_W-1 -: SEL_W];

    always_comb begin
        unique case (sel)
            3'b100:         seg = SEG_KDIRECT_C;
            3'b101:         seg = SEG_KDIRECT_U;
            3'b110, 3'b111: seg = SEG_KMAPPED;
            default:        seg = SEG_USER;
        endcase
    end

    assign direct       = (seg == SEG_KDIRECT_C) || (seg == SEG_KDIRECT_U);
    assign mapped       = !direct;
    assign cacheable    = (seg != SEG_KDIRECT_U);
    assign super_window = (sel == SUPER_SEL);
    assign paddr        = direct ? {{SEL_W{1'b0}}, vaddr[DIRECT_W-1:0]} : '0;

endmodule

// File: rtl/access_permit.sv
module access_permit
    import privseg_pkg::*;
(
    input  priv_mode_e level,
    input  seg_e       seg,
    input  logic       super_window,
    input  acc_e       kind,
    output logic       addr_err,
    output logic       err_store
);

    logic allowed;

    always_comb begin
        unique case (level)
            MODE_KERNEL: allowed = 1'b1;
            MODE_SUPER:  allowed = (seg == SEG_USER) || super_window;
            MODE_USER:   allowed = (seg == SEG_USER);
            default:     allowed = 1'b0;
        endcase
    end

    assign addr_err  = !allowed;
    assign err_store = !allowed && (kind == ACC_STORE);

endmodule

// File: rtl/privseg_decoder.sv
module privseg_decoder
    import privseg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  in_mode_field,
    input  logic        in_err_lvl,
    input  logic        in_exc_lvl,
    input  logic [31:0] in_vaddr,
    input  logic [1:0]  in_kind,
    output logic        out_valid,
    output logic [1:0]  out_mode,
    output logic [1:0]  out_seg,
    output logic        out_mapped,
    output logic [31:0] out_paddr,
    output logic        out_cacheable,
    output logic        out_addr_err,
    output logic        out_err_is_store
);

    priv_mode_e   lvl_c;
    seg_e         seg_c;
    logic         mapped_c;
    logic [VADDR_W-1:0] paddr_c;
    logic         cache_c;
    logic         superwin_c;
    logic         err_c;
    logic         errst_c;
    decode_t      dec_c;
    decode_t      dec_q;
    hold_state_e  state_q;
    hold_state_e  state_d;

    priv_level_decode u_level (
        .mode_field (in_mode_field),
        .err_lvl    (in_err_lvl),
        .exc_lvl    (in_exc_lvl),
        .level      (lvl_c)
    );

    vaddr_segment_map u_segmap (
        .vaddr        (in_vaddr),
        .seg          (seg_c),
        .mapped       (mapped_c),
        .paddr        (paddr_c),
        .cacheable    (cache_c),
        .super_window (superwin_c)
    );

    access_permit u_permit (
        .level        (lvl_c),
        .seg          (seg_c),
        .super_window (superwin_c),
        .kind         (acc_e'(in_kind)),
        .addr_err     (err_c),
        .err_store    (errst_c)
    );

    always_comb begin
        dec_c.mode      = lvl_c;
        dec_c.seg       = seg_c;
        dec_c.mapped    = mapped_c;
        dec_c.paddr     = paddr_c;
        dec_c.cacheable = cache_c;
        dec_c.addr_err  = err_c;
        dec_c.err_store = errst_c;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (in_valid) state_d = ST_LOADED;
            ST_LOADED: state_d = ST_LOADED;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output register: captures on in_valid, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)        dec_q <= '0;
        else if (in_valid) dec_q <= dec_c;
    end

    assign out_valid        = (state_q == ST_LOADED);
    assign out_mode         = dec_q.mode;
    assign out_seg          = dec_q.seg;
    assign out_mapped       = dec_q.mapped;
    assign out_paddr        = dec_q.paddr;
    assign out_cacheable    = dec_q.cacheable;
    assign out_addr_err     = dec_q.addr_err;
    assign out_err_is_store = dec_q.err_store;

    // Either exception flag forces kernel level
    p_flag_forces_kernel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_err_lvl || in_exc_lvl) |=> out_mode == MODE_KERNEL);

    // Direct segments never carry the top three address bits
    p_direct_low_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_mapped |-> out_paddr[31:29] == 3'b000);

    // The uncached direct segment is never cacheable
    p_uncached_seg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_seg == SEG_KDIRECT_U |-> !out_cacheable);

    // A user-level access above 2 GB faults
    p_user_high_faults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_err_lvl && !in_exc_lvl && in_mode_field[1] && in_vaddr[31]
        |=> out_addr_err);

    // Kernel level reaches everything
    p_kernel_no_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_err_lvl || in_exc_lvl) |=> !out_addr_err);

    // A store-type fault is always a fault
    p_store_fault_implies_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_err_is_store |-> out_addr_err);

    // Capture and hold behaviour
    p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_paddr) && $stable(out_seg) && $stable(out_mode)
                      && $stable(out_addr_err) && $stable(out_valid));

endmodule

// File: tb/sim_privseg_decoder.sv
module sim_privseg_decoder;

    localparam real HALF_NS   = 4.0;
    localparam int  WD_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_mode_field;
    logic        in_err_lvl;
    logic        in_exc_lvl;
    logic [31:0] in_vaddr;
    logic [1:0]  in_kind;
    logic        out_valid;
    logic [1:0]  out_mode;
    logic [1:0]  out_seg;
    logic        out_mapped;
    logic [31:0] out_paddr;
    logic        out_cacheable;
    logic        out_addr_err;
    logic        out_err_is_store;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(HALF_NS) clk = ~clk;

    privseg_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_mode_field(in_mode_field), .in_err_lvl(in_err_lvl),
        .in_exc_lvl(in_exc_lvl), .in_vaddr(in_vaddr), .in_kind(in_kind),
        .out_valid(out_valid), .out_mode(out_mode), .out_seg(out_seg),
        .out_mapped(out_mapped), .out_paddr(out_paddr),
        .out_cacheable(out_cacheable), .out_addr_err(out_addr_err),
        .out_err_is_store(out_err_is_store)
    );

    typedef struct packed {
        logic [1:0]  mf;
        logic        erl;
        logic        exl;
        logic [31:0] va;
        logic [1:0]  kind;
        logic [1:0]  e_mode;
        logic [1:0]  e_seg;
        logic        e_map;
        logic [31:0] e_pa;
        logic        e_cache;
        logic        e_err;
        logic        e_st;
    } vec_t;

    localparam int NV = 15;
    // kind: 0 load, 1 store, 2 fetch; mode: 0 kernel, 1 super, 2 user
    localparam vec_t VECS [NV] = '{
        '{2'd2,1'b0,1'b0,32'h0000_1000,2'd0, 2'd2,2'd0,1'b1,32'h0,          1'b1,1'b0,1'b0},
        '{2'd2,1'b0,1'b0,32'h8000_0010,2'd0, 2'd2,2'd1,1'b0,32'h0000_0010,  1'b1,1'b1,1'b0},
        '{2'd2,1'b0,1'b0,32'hA000_0020,2'd1, 2'd2,2'd2,1'b0,32'h0000_0020,  1'b0,1'b1,1'b1},
        '{2'd2,1'b0,1'b0,32'hC000_0000,2'd2, 2'd2,2'd3,1'b1,32'h0,          1'b1,1'b1,1'b0},
        '{2'd1,1'b0,1'b0,32'hC000_0040,2'd1, 2'd1,2'd3,1'b1,32'h0,          1'b1,1'b0,1'b0},
        '{2'd1,1'b0,1'b0,32'hDFFF_FFFC,2'd0, 2'd1,2'd3,1'b1,32'h0,          1'b1,1'b0,1'b0},
        '{2'd1,1'b0,1'b0,32'hE000_0000,2'd1, 2'd1,2'd3,1'b1,32'h0,          1'b1,1'b1,1'b1},
        '{2'd1,1'b0,1'b0,32'h9FFF_FFFF,2'd0, 2'd1,2'd1,1'b0,32'h1FFF_FFFF,  1'b1,1'b1,1'b0},
        '{2'd1,1'b0,1'b0,32'h7FFF_FFFF,2'd1, 2'd1,2'd0,1'b1,32'h0,          1'b1,1'b0,1'b0},
        '{2'd0,1'b0,1'b0,32'hBFC0_0000,2'd2, 2'd0,2'd2,1'b0,32'h1FC0_0000,  1'b0,1'b0,1'b0},
        '{2'd2,1'b0,1'b1,32'hFFFF_FFF0,2'd1, 2'd0,2'd3,1'b1,32'h0,          1'b1,1'b0,1'b0},
        '{2'd2,1'b1,1'b0,32'hA000_0000,2'd0, 2'd0,2'd2,1'b0,32'h0,          1'b0,1'b0,1'b0},
        '{2'd3,1'b0,1'b0,32'h8000_0000,2'd1, 2'd2,2'd1,1'b0,32'h0,          1'b1,1'b1,1'b1},
        '{2'd1,1'b1,1'b1,32'h9FFF_FFFF,2'd2, 2'd0,2'd1,1'b0,32'h1FFF_FFFF,  1'b1,1'b0,1'b0},
        '{2'd2,1'b0,1'b0,32'h8000_0000,2'd2, 2'd2,2'd1,1'b0,32'h0,          1'b1,1'b1,1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        in_valid      = 1'b1;
        in_mode_field = v.mf;
        in_err_lvl    = v.erl;
        in_exc_lvl    = v.exl;
        in_vaddr      = v.va;
        in_kind       = v.kind;
        @(negedge clk);
        in_valid      = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_mode_field = 2'd0;
        in_err_lvl = 1'b0; in_exc_lvl = 1'b0; in_vaddr = '0; in_kind = 2'd0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "out_valid",  {31'd0, out_valid}, 32'd0);
        check("R12", "out_paddr",  out_paddr, 32'd0);
        check("R12", "misc", {24'd0, out_mode, out_seg, out_mapped, out_cacheable,
              out_addr_err, out_err_is_store}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check("R11", "out_valid", {31'd0, out_valid}, 32'd1);
            check((VECS[i].e_mode == 2'd0) ? "R1" : "R2", "mode",
                  {30'd0, out_mode}, {30'd0, VECS[i].e_mode});
            check("R3", "seg", {30'd0, out_seg}, {30'd0, VECS[i].e_seg});
            check("R4", "mapped", {31'd0, out_mapped}, {31'd0, VECS[i].e_map});
            check(VECS[i].e_map ? "R4" : "R5", "paddr", out_paddr, VECS[i].e_pa);
            check("R6", "cacheable", {31'd0, out_cacheable}, {31'd0, VECS[i].e_cache});
            check((VECS[i].e_mode == 2'd2) ? "R7" :
                  (VECS[i].e_mode == 2'd1) ? "R8" : "R9", "addr_err",
                  {31'd0, out_addr_err}, {31'd0, VECS[i].e_err});
            check("R10", "err_is_store", {31'd0, out_err_is_store}, {31'd0, VECS[i].e_st});
        end

        // R11: hold while in_valid is low, even as inputs change
        apply(VECS[9]);
        in_mode_field = 2'd2; in_vaddr = 32'hE000_1234; in_kind = 2'd1;
        repeat (3) @(negedge clk);
        check("R11", "held paddr", out_paddr, 32'h1FC0_0000);
        check("R11", "held seg", {30'd0, out_seg}, 32'd2);
        check("R11", "held err", {31'd0, out_addr_err}, 32'd0);
        check("R11", "held valid", {31'd0, out_valid}, 32'd1);

        // R12: reset again clears a loaded decode
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", "valid after reset", {31'd0, out_valid}, 32'd0);
        check("R12", "paddr after reset", out_paddr, 32'd0);
        rst_n = 1'b1;

        finish_run();
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule